// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Chain

This block is the digital main-counter chain of a fractional-N synthesiser. It divides a fast input clock, which stands in for the VCO, by a programmable ratio of P·M + A + F/32 and emits a one-clock pulse per output period for a phase detector. The dual-modulus prescaler is modelled as a counter that divides by P or P+1. P is 32 in the high-range mode and 16 in the low-range mode. A swallow count A sets how many prescaler cycles in each output period run at P+1. The remaining M−A cycles of the period run at P.

A 5-bit fractional accumulator adds F at each period boundary. Whenever that sum wraps past 31, the period just starting is one input clock longer. Averaged over 32 periods, this gives the fractional part F/32. An even F repeats its pattern over fewer periods, so the effective denominator reduces to 16, 8, 4 or 2 without any special logic.

The configuration is sampled in three situations: during reset, at each period boundary, and on every cycle while it is illegal. Changes therefore never cut a period short. An illegal setting raises a flag and stops the output.

Top module: `fracn_div_chain`

## Requirements
- R1: With lo_mode = 0 and f_in = 0, consecutive div_pulse rising edges are exactly 32·M + A input clocks apart.
- R2: With lo_mode = 1 and f_in = 0, consecutive div_pulse rising edges are exactly 16·M + A input clocks apart.
- R3: Each period lasts either the base count (P·M + A) or the base count plus one. The extra clock is governed by a 5-bit accumulator:
  - The accumulator holds F after reset.
  - F is added modulo 32 at the start of each later period.
  - A period is one clock longer when its add wraps.
  - Any 32 consecutive periods therefore total 32·(P·M + A) + F clocks.
- R4: An even F reduces its denominator. With F = 12, every 8 consecutive periods contain exactly 3 extra clocks. With F = 16, long and short periods alternate.
- R5: A = 0 gives exactly P·M clocks, and A = M − 1 is accepted and gives P·M + M − 1.
- R6: In lo_mode = 1 only bits 3:0 of a_in are used; bit 4 has no effect on the period or on the validity flag.
- R7: If M < 3, or if the effective A ≥ M, cfg_err is 1 and div_pulse stays 0.
- R8: While the configuration is illegal, the inputs are re-sampled every clock. cfg_err drops one clock after a legal setting is applied, and pulses then resume at the new period.
- R9: A configuration change made during a period takes effect from the next period. The period in progress keeps its old length.
- R10: During reset div_pulse is 0, and every div_pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock standing in for the VCO |
| rst | input | 1 | Synchronous active-high reset |
| lo_mode | input | 1 | 0: prescaler 32/33; 1: prescaler 16/17 |
| m_in | input | 9 | Main counter value M (legal 3..511) |
| a_in | input | 5 | Swallow count A (bits 3:0 only in lo_mode) |
| f_in | input | 5 | Fractional numerator F over 32 |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| cfg_err | output | 1 | High while the sampled configuration is illegal |

## Verification
The hardest behaviour to reach from the ports is the exact sequence of one-clock stretches that the accumulator produces, because each stretch depends on every add since reset. The stimulus holds a fixed F for 33 output periods. The bench runs its own accumulator model alongside, so every single interval is compared with its own expected value, not just the average. A second hard case is a configuration change that lands exactly at a period boundary. The bench changes M in the half-clock just after a pulse appears. The period already under way must then keep the old length, and the next period must take the new one.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int P_HI   = 32;
    localparam int P_LO   = 16;
    localparam int M_W    = 9;
    localparam int A_W    = 5;
    localparam int A_LO_W = 4;
    localparam int F_W    = 5;
    localparam int M_MIN  = 3;
    localparam int PC_W   = $clog2(P_HI + 3);

    localparam logic [A_W-1:0] A_LO_MASK = A_W'((1 << A_LO_W) - 1);

    typedef struct packed {
        logic           lo_mode;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } fdc_cfg_t;

    function automatic logic [A_W-1:0] eff_swallow(fdc_cfg_t c);
        return c.lo_mode ? (c.a & A_LO_MASK) : c.a;
    endfunction

    function automatic logic cfg_ok(fdc_cfg_t c);
        return (c.m >= M_W'(M_MIN)) && (M_W'(eff_swallow(c)) < c.m);
    endfunction

    function automatic logic [PC_W-1:0] presc_base(logic lo);
        return lo ? PC_W'(P_LO) : PC_W'(P_HI);
    endfunction

endpackage

// File: rtl/fdc_prescaler.sv
module fdc_prescaler
    import fdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic lo_mode,
    input  logic swallow,
    input  logic extra,
    output logic pre_tc
);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] modv;

    always_comb begin
        modv = presc_base(lo_mode) + PC_W'(swallow) + PC_W'(extra);
    end

    assign pre_tc = run && (pc == modv - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc <= '0;
        end else if (pre_tc) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (pc < modv)) else $error("prescaler count out of range"); // R1

endmodule

// File: rtl/fdc_swallow.sv
module fdc_swallow
    import fdc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           pre_tc,
    input  logic [M_W-1:0] m,
    input  logic [A_W-1:0] a_eff,
    output logic           swallow,
    output logic           last,
    output logic           period_end
);

    logic [M_W-1:0] mc;

    assign swallow    = M_W'(a_eff) > mc;
    assign last       = (mc == m - 1'b1);
    assign period_end = pre_tc && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mc <= '0;
        end else if (pre_tc) begin
            mc <= last ? '0 : mc + 1'b1;
        end
    end

    AST_MC_BELOW_M: assert property (@(posedge clk) disable iff (rst)
        run |-> (mc < m)) else $error("main count beyond M"); // R1

endmodule

// File: rtl/fdc_frac_acc.sv
module fdc_frac_acc
    import fdc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           step,
    input  logic [F_W-1:0] f_in,
    output logic           carry
);

    logic [F_W-1:0] acc;
    logic [F_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, f_in};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc   <= f_in;
            carry <= 1'b0;
        end else if (step) begin
            acc   <= sum[F_W-1:0];
            carry <= sum[F_W];
        end
    end

    AST_CARRY_NEEDS_FRAC: assert property (@(posedge clk) disable iff (rst)
        $rose(carry) |-> ($past(f_in) != '0)) else $error("carry with zero fraction"); // R3

endmodule

// File: rtl/fracn_div_chain.sv
module fracn_div_chain
    import fdc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           lo_mode,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic [F_W-1:0] f_in,
    output logic           div_pulse,
    output logic           cfg_err
);

    fdc_cfg_t       cfg_q;
    fdc_cfg_t       cfg_d;
    logic           ok;
    logic [A_W-1:0] a_eff;
    logic           pre_tc;
    logic           swallow;
    logic           last;
    logic           period_end;
    logic           carry;

    always_comb begin
        cfg_d.lo_mode = lo_mode;
        cfg_d.m       = m_in;
        cfg_d.a       = a_in;
    end

    assign ok      = cfg_ok(cfg_q);
    assign a_eff   = eff_swallow(cfg_q);
    assign cfg_err = !ok;

    always_ff @(posedge clk) begin
        if (rst || !ok || period_end) begin
            cfg_q <= cfg_d;
        end
    end

    fdc_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (ok),
        .lo_mode (cfg_q.lo_mode),
        .swallow (swallow),
        .extra   (last && carry),
        .pre_tc  (pre_tc)
    );

    fdc_swallow u_swl (
        .clk        (clk),
        .rst        (rst),
        .run        (ok),
        .pre_tc     (pre_tc),
        .m          (cfg_q.m),
        .a_eff      (a_eff),
        .swallow    (swallow),
        .last       (last),
        .period_end (period_end)
    );

    fdc_frac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .restart (!ok),
        .step    (period_end),
        .f_in    (f_in),
        .carry   (carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= period_end;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse) else $error("pulse wider than one clock"); // R10

    AST_SILENT_WHEN_BAD: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !div_pulse) else $error("pulse with illegal configuration"); // R7

endmodule

// File: tb/sim_fracn_div_chain.sv
module sim_fracn_div_chain;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_mode = 1'b0;
    logic [8:0] m_in = 9'd3;
    logic [4:0] a_in = 5'd1;
    logic [4:0] f_in = 5'd0;
    logic       div_pulse;
    logic       cfg_err;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int ivl [0:40];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fracn_div_chain u0 (
        .clk       (clk),
        .rst       (rst),
        .lo_mode   (lo_mode),
        .m_in      (m_in),
        .a_in      (a_in),
        .f_in      (f_in),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    task automatic check(bit good, string req, int act, int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int base_of(bit lo, int m, int a);
        return lo ? (16 * m + (a % 16)) : (32 * m + a);
    endfunction

    task automatic apply_reset(bit lo, int m, int a, int f);
        @(negedge clk);
        lo_mode = lo;
        m_in    = 9'(m);
        a_in    = 5'(a);
        f_in    = 5'(f);
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R10 pulse low in reset", int'(div_pulse), 0);
        rst = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        t = -1;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (div_pulse) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic grab(int n);
        int t0;
        int t1;
        wait_pulse(t0);
        for (int i = 0; i < n; i++) begin
            wait_pulse(t1);
            ivl[i] = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
            t0 = t1;
        end
    endtask

    task automatic fixed_period(bit lo, int m, int a, string req);
        int exp;
        exp = base_of(lo, m, a);
        apply_reset(lo, m, a, 0);
        check(cfg_err == 1'b0, req, int'(cfg_err), 0);
        grab(3);
        for (int i = 0; i < 3; i++) check(ivl[i] == exp, req, ivl[i], exp);
    endtask

    task automatic frac_model(bit lo, int m, int a, int f, int n, string req);
        int base;
        int macc;
        int s;
        int c;
        base = base_of(lo, m, a);
        apply_reset(lo, m, a, f);
        grab(n);
        macc = f;
        for (int i = 0; i < n; i++) begin
            s    = macc + f;
            c    = (s >= 32) ? 1 : 0;
            macc = s % 32;
            check(ivl[i] == base + c, req, ivl[i], base + c);
        end
    endtask

    task automatic t_r1();
        fixed_period(0, 3, 1, "R1");
        fixed_period(0, 10, 7, "R1");
    endtask

    task automatic t_r2();
        fixed_period(1, 16, 5, "R2");
        fixed_period(1, 3, 2, "R2");
    endtask

    task automatic t_r5();
        fixed_period(0, 5, 0, "R5 A=0");
        fixed_period(0, 4, 3, "R5 A=M-1");
    endtask

    task automatic t_r6();
        fixed_period(1, 16, 21, "R6 bit4 ignored");
        fixed_period(1, 3, 18, "R6 bit4 ignored");
    endtask

    task automatic t_r3();
        int sum;
        frac_model(0, 3, 1, 7, 33, "R3 F=7");
        sum = 0;
        for (int i = 0; i < 32; i++) sum += ivl[i];
        check(sum == 32 * 97 + 7, "R3 sum F=7", sum, 32 * 97 + 7);
        frac_model(1, 3, 1, 31, 33, "R3 F=31");
        sum = 0;
        for (int i = 1; i < 33; i++) sum += ivl[i];
        check(sum == 32 * 49 + 31, "R3 sum F=31", sum, 32 * 49 + 31);
    endtask

    task automatic t_r4();
        int sum;
        frac_model(0, 3, 1, 12, 16, "R4 F=12");
        for (int g = 0; g < 2; g++) begin
            sum = 0;
            for (int i = 0; i < 8; i++) sum += ivl[g * 8 + i];
            check(sum == 8 * 97 + 3, "R4 F=12 per 8", sum, 8 * 97 + 3);
        end
        frac_model(0, 3, 1, 16, 8, "R4 F=16");
        for (int i = 0; i < 8; i += 2) begin
            sum = ivl[i] + ivl[i + 1];
            check(sum == 2 * 97 + 1, "R4 F=16 pair", sum, 2 * 97 + 1);
        end
    endtask

    task automatic t_r7_r8();
        int seen;
        apply_reset(0, 2, 1, 0);
        check(cfg_err == 1'b1, "R7 M<3 flag", int'(cfg_err), 1);
        seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        check(seen == 0, "R7 M<3 silent", seen, 0);
        m_in = 9'd4;
        a_in = 5'd4;
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 A>=M flag", int'(cfg_err), 1);
        seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        check(seen == 0, "R7 A>=M silent", seen, 0);
        m_in = 9'd3;
        a_in = 5'd1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R8 flag clears", int'(cfg_err), 0);
        grab(3);
        for (int i = 0; i < 3; i++) check(ivl[i] == 97, "R8 resume", ivl[i], 97);
    endtask

    task automatic t_r9();
        int t0;
        int t1;
        int t2;
        int t3;
        apply_reset(0, 3, 1, 0);
        wait_pulse(t0);
        wait_pulse(t1);
        m_in = 9'd5;
        wait_pulse(t2);
        check(t2 - t1 == 97, "R9 old period kept", t2 - t1, 97);
        wait_pulse(t3);
        check(t3 - t2 == 161, "R9 new period", t3 - t2, 161);
    endtask

    initial begin
        t_r1();
        t_r2();
        t_r5();
        t_r6();
        t_r3();
        t_r4();
        t_r7_r8();
        t_r9();
        report();
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d cycles", WDOG_CYC, 0);
        report();
    end

endmodule